// File: doc/BRIEF.md
# Multiplexed Fetch Bus Controller

This block runs instruction fetches over an external program-memory interface in which one byte-wide port carries both the low address byte and the returned instruction byte. For each fetch it produces an address-latch strobe, an active-low program-store strobe, and the drive or release control of the shared port. Every event is placed on an edge of the input clock.

A requester raises `fetch_req` together with a fetch address. The request is taken on a rising clock edge where the controller is idle, or where it is in the last clock of a bus cycle. Requests on any other edge are ignored. The controller has no ready output, so the requester times its requests from the fixed bus-cycle lengths below.

In default mode a bus cycle lasts four clocks. The address phase is two clocks and the data phase is two clocks. With page mode selected, a back-to-back fetch whose high address byte matches the previous fetch skips the address phase. That fetch takes two clocks, and the program-store strobe stays low between the two fetches.

Top module: `mux_bus_ctrl`

## Requirements
Edge E0 is the rising edge that takes a request. E1, E2 and the following edges are the rising edges after it.

- R1: While `rst` is high, and on the first edge after it, `ale` is 0, `psen_n` is 1, `port_oe` is 0 and `rd_valid` is 0.
- R2: After a full-cycle request is taken at E0, `ale` rises at E0 and falls on the falling clock edge between E1 and E2, so it is high for 1.5 clocks.
- R3: From E0 to E2, `port_oe` is 1 and `port_out` carries the low address byte. From E2 to the end of the bus cycle, `port_oe` is 0. `port_oe` and a low `psen_n` are never true together.
- R4: On a full cycle, `psen_n` is high from E0 to E2, low from E2 to E4, and back high at E4 unless a page hit follows.
- R5: At the edge that ends the data phase, `rd_data` takes the value of `port_in`, and `rd_valid` is 1 for exactly the one following clock.
- R6: `addr_hi` shows the high byte of the taken address from its accepting edge until the next request is taken.
- R7: A request presented in the last clock of a bus cycle is taken at once. In default mode, back-to-back fetches therefore repeat every four clocks, with one `ale` pulse each.
- R8: Page hit: a request is taken at the end of a bus cycle, `page_mode` is 1, and the high byte equals the previous fetch's. Then `psen_n` stays 0, `ale` stays 0 and `port_oe` stays 0, and the data is captured two clocks later.
- R9: A page-mode request that misses the page, or one taken while idle (including the first after reset), runs a full four-clock cycle with an `ale` pulse.
- R10: A request presented while a bus cycle is running, other than in its last clock, has no effect on the outputs or on `addr_hi`.
- R11: With `page_mode` at 0, a back-to-back fetch in the same page still runs a full four-clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Fetch request, sampled on rising edges |
| fetch_addr | input | ADDR_W | Fetch address |
| page_mode | input | 1 | Selects page mode for the request being taken |
| port_in | input | DATA_W | Value read from the shared port |
| ale | output | 1 | Address-latch strobe |
| psen_n | output | 1 | Active-low program-store strobe |
| port_out | output | DATA_W | Value driven onto the shared port |
| port_oe | output | 1 | Shared-port output enable |
| addr_hi | output | ADDR_W-DATA_W | High address byte of the current fetch |
| rd_valid | output | 1 | One-clock pulse marking fresh read data |
| rd_data | output | DATA_W | Captured instruction byte |

## Verification
A lone default fetch from idle fixes the reference edge positions of `ale`, `port_oe` and `psen_n`. The half-clock fall of `ale` is sampled after a falling clock edge. Two back-to-back pairs separate page hits from full cycles:
- page mode on with the same high byte, which should hit;
- page mode on with a different high byte, which should miss;
- page mode off with the same high byte, which should run a full cycle.

The `psen_n` level at the junction edge and the cycle in which the second data byte is captured show which path was taken. A request held through the middle of a running bus cycle, and dropped before its last clock, shows that requests outside the acceptance window are ignored.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [1:0] {
    PH_ADDR0 = 2'd0,
    PH_ADDR1 = 2'd1,
    PH_DATA0 = 2'd2,
    PH_DATA1 = 2'd3
  } phase_t;
endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req,
  input  logic [HI_W-1:0] req_hi,
  input  logic            page_mode,
  output logic            busy,
  output phase_t          phase,
  output logic            take,
  output logic            hit,
  output logic            last
);
  logic [HI_W-1:0] cur_hi;

  assign last = busy && (phase == PH_DATA1);
  assign take = req && (!busy || last);
  assign hit  = take && last && page_mode && (req_hi == cur_hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      phase  <= PH_ADDR0;
      cur_hi <= '0;
    end else if (take) begin
      busy   <= 1'b1;
      phase  <= hit ? PH_DATA0 : PH_ADDR0;
      cur_hi <= req_hi;
    end else if (last) begin
      busy  <= 1'b0;
      phase <= PH_ADDR0;
    end else if (busy) begin
      phase <= phase_t'(phase + 2'd1);
    end
  end

  // R3: the address phase always hands over to the data phase
  addr_to_data_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && phase == PH_ADDR1) |=> (busy && phase == PH_DATA0));

  // R4: a cycle ending with no new request returns to idle
  end_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (last && !req) |=> !busy);
endmodule

// File: rtl/mbus_ale_shaper.sv
module mbus_ale_shaper (
  input  logic clk,
  input  logic rst,
  input  logic ale_rise,
  input  logic ale_end,
  input  logic cut_next,
  output logic ale
);
  logic ale_pos;
  logic ale_cut;

  always_ff @(posedge clk) begin
    if (rst)           ale_pos <= 1'b0;
    else if (ale_rise) ale_pos <= 1'b1;
    else if (ale_end)  ale_pos <= 1'b0;
  end

  // falling-edge flop trims the pulse by half a clock
  always_ff @(negedge clk) begin
    if (rst) ale_cut <= 1'b0;
    else     ale_cut <= cut_next;
  end

  assign ale = ale_pos & ~ale_cut;
endmodule

// File: rtl/mbus_capture.sv
module mbus_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [DATA_W-1:0] port_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= strobe;
      if (strobe) rd_data <= port_in;
    end
  end

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fetch_req,
  input  logic [ADDR_W-1:0]        fetch_addr,
  input  logic                     page_mode,
  input  logic [DATA_W-1:0]        port_in,
  output logic                     ale,
  output logic                     psen_n,
  output logic [DATA_W-1:0]        port_out,
  output logic                     port_oe,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic   busy, take, hit, last;
  phase_t phase;
  logic   full_start, addr_done;

  mbus_seq #(.HI_W(HI_W)) u_seq (
    .clk(clk), .rst(rst), .req(fetch_req),
    .req_hi(fetch_addr[ADDR_W-1:DATA_W]), .page_mode(page_mode),
    .busy(busy), .phase(phase), .take(take), .hit(hit), .last(last)
  );

  assign full_start = take && !hit;
  assign addr_done  = busy && (phase == PH_ADDR1);

  mbus_ale_shaper u_ale (
    .clk(clk), .rst(rst), .ale_rise(full_start), .ale_end(addr_done),
    .cut_next(addr_done), .ale(ale)
  );

  mbus_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .strobe(last), .port_in(port_in),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      psen_n   <= 1'b1;
      port_oe  <= 1'b0;
      port_out <= '0;
      addr_hi  <= '0;
    end else begin
      if (take) addr_hi <= fetch_addr[ADDR_W-1:DATA_W];
      if (full_start) begin
        port_oe  <= 1'b1;
        port_out <= fetch_addr[DATA_W-1:0];
        psen_n   <= 1'b1;
      end else if (hit) begin
        psen_n <= 1'b0;
      end else if (addr_done) begin
        port_oe <= 1'b0;
        psen_n  <= 1'b0;
      end else if (last) begin
        psen_n <= 1'b1;
      end
    end
  end

  // R3
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    !psen_n |-> !port_oe);

  // R2
  ale_psen_excl_chk: assert property (@(posedge clk) disable iff (rst)
    ale |-> psen_n);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (psen_n && !port_oe && !rd_valid));
endmodule

// File: tb/sim_mux_bus_ctrl.sv
module sim_mux_bus_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        fetch_req;
  logic [15:0] fetch_addr;
  logic        page_mode;
  logic [7:0]  port_in;
  logic        ale, psen_n, port_oe, rd_valid;
  logic [7:0]  port_out, addr_hi, rd_data;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mux_bus_ctrl u0 (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .page_mode(page_mode), .port_in(port_in), .ale(ale), .psen_n(psen_n),
    .port_out(port_out), .port_oe(port_oe), .addr_hi(addr_hi),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1; fetch_req = 1'b0; fetch_addr = '0; page_mode = 1'b0; port_in = '0;
    step();
    chk("R1 reset psen_n", psen_n, 1);
    chk("R1 reset ale", ale, 0);
    chk("R1 reset oe", port_oe, 0);
    chk("R1 reset valid", rd_valid, 0);
    step();
    rst = 1'b0;
    step();
    chk("R1 after reset psen_n", psen_n, 1);
    chk("R1 after reset oe", port_oe, 0);
  endtask

  // single default fetch from idle; a stray request is held mid-cycle (R10)
  task automatic t_single(input logic [15:0] a, input logic [7:0] d);
    fetch_req = 1'b1; fetch_addr = a; page_mode = 1'b0;
    step();                                  // E0
    fetch_req = 1'b0;
    chk("R2 ale rises", ale, 1);
    chk("R3 oe on", port_oe, 1);
    chk("R3 low addr", port_out, a[7:0]);
    chk("R6 addr_hi", addr_hi, a[15:8]);
    chk("R4 psen high in addr", psen_n, 1);
    #2; chk("R2 ale after first half", ale, 1);
    fetch_req = 1'b1; fetch_addr = 16'hFFFF;  // R10 stray request
    step();                                  // E1
    chk("R2 ale at E1", ale, 1);
    chk("R3 oe at E1", port_oe, 1);
    #2; chk("R2 ale falls mid", ale, 0);
    step();                                  // E2
    chk("R4 psen low", psen_n, 0);
    chk("R3 oe off", port_oe, 0);
    chk("R10 addr_hi kept", addr_hi, a[15:8]);
    port_in = d;
    step();                                  // E3
    fetch_req = 1'b0;
    chk("R4 psen low E3", psen_n, 0);
    step();                                  // E4
    chk("R5 valid", rd_valid, 1);
    chk("R5 data", rd_data, d);
    chk("R4 psen rises", psen_n, 1);
    chk("R10 no new cycle ale", ale, 0);
    chk("R10 no new cycle oe", port_oe, 0);
    chk("R10 addr_hi unchanged", addr_hi, a[15:8]);
    step();
    chk("R5 valid one clock", rd_valid, 0);
    port_in = '0;
    step();
  endtask

  // two fetches back to back; second request given in last clock of first
  task automatic t_pair(input logic pm, input logic [15:0] a1, input logic [15:0] a2,
                        input logic [7:0] d1, input logic [7:0] d2, input logic exp_hit,
                        input string tag);
    fetch_req = 1'b1; fetch_addr = a1; page_mode = pm;
    step();                                  // E0
    fetch_req = 1'b0;
    chk({tag, " R9 first ale"}, ale, 1);
    step();                                  // E1
    step();                                  // E2
    port_in = d1;
    step();                                  // E3
    fetch_req = 1'b1; fetch_addr = a2;
    step();                                  // E4
    fetch_req = 1'b0;
    chk({tag, " R5 first data"}, rd_data, d1);
    chk({tag, " R5 first valid"}, rd_valid, 1);
    chk({tag, " R6 addr_hi second"}, addr_hi, a2[15:8]);
    if (exp_hit) begin
      chk({tag, " R8 psen held low"}, psen_n, 0);
      chk({tag, " R8 no ale"}, ale, 0);
      chk({tag, " R8 port released"}, port_oe, 0);
      port_in = d2;
      step();                                // E5
      chk({tag, " R8 psen low E5"}, psen_n, 0);
      step();                                // E6
      chk({tag, " R8 hit data"}, rd_data, d2);
      chk({tag, " R8 hit valid"}, rd_valid, 1);
      chk({tag, " R4 psen high end"}, psen_n, 1);
    end else begin
      chk({tag, " R7 ale again"}, ale, 1);
      chk({tag, " R7 psen high"}, psen_n, 1);
      chk({tag, " R7 oe again"}, port_oe, 1);
      chk({tag, " R7 low addr"}, port_out, a2[7:0]);
      step();                                // E5
      #2; chk({tag, " R2 ale falls"}, ale, 0);
      step();                                // E6
      chk({tag, " R4 psen low"}, psen_n, 0);
      port_in = d2;
      step();                                // E7
      chk({tag, " R5 no early valid"}, rd_valid, 0);
      step();                                // E8
      chk({tag, " R5 full data"}, rd_data, d2);
      chk({tag, " R5 full valid"}, rd_valid, 1);
    end
    port_in = '0;
    step();
    step();
  endtask

  initial begin
    t_reset();
    t_single(16'h12A5, 8'h3C);
    t_pair(1'b1, 16'h4010, 16'h4011, 8'hA1, 8'hB2, 1'b1, "hit R8");
    t_pair(1'b1, 16'h4010, 16'h5011, 8'hC3, 8'hD4, 1'b0, "miss R9");
    t_pair(1'b0, 16'h7720, 16'h7721, 8'hE5, 8'hF6, 1'b0, "nopage R11");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule